// File: doc/BRIEF.md
# Misc Control Register with Modify Aliases

This block holds one 64-bit miscellaneous control/status word behind a word-addressed register bus. Software reaches the word through three consecutive word offsets: one direct location that is written with plain data, one alias that modifies the current contents, and one alias that ORs new bits in. With the default configuration the modify alias performs a bitwise AND with the write data. A parameter switches to a second variant in which that alias clears the whole word and ignores the data.

Only the top 16 bits of the word are stored. The low 48 bits always read back as zero. The most significant stored bit is brought out as an interrupt line to a consumer elsewhere on the chip. Requests use a valid/ready handshake with a byte address; the word offset is the byte address shifted right by three. Only full 8-byte accesses are legal. Every accepted request gets a one-cycle-later response carrying read data and an error flag.

Top module: `misc_alias_reg`

## Requirements
- R1: After reset the stored word is zero, `irqOut` is 0, `rspValid` is 0 and `rspErr` is 0.
- R2: An 8-byte write at the base word offset (0x4020 by default, 0x6080 in the clear variant) stores write data bits 63:48. Bits 47:0 of the data are dropped.
- R3: In the AND variant (`CLEAR_VARIANT`=0), an 8-byte write at base+1 stores (current AND data), keeping only bits 63:48.
- R4: An 8-byte write at base+2 stores (current OR data), keeping only bits 63:48.
- R5: In the clear variant (`CLEAR_VARIANT`=1), an 8-byte write at base+1 sets the word to zero whatever the data, so `irqOut` falls.
- R6: `irqOut` equals bit 63 of the stored word. It takes its new value in the cycle after the write is accepted.
- R7: Every accepted request gives `rspValid`=1 one cycle later. An 8-byte read at the base returns the word as held before that cycle's edge, with bits 47:0 zero. Reads at base+1 and base+2 return zero with no error.
- R8: A request to any word offset other than base, base+1 or base+2 gives `rspErr`=1 for one cycle and `rspRdata`=0, and leaves the word unchanged.
- R9: A request whose `reqSize` is not 8 gives `rspErr`=1 and `rspRdata`=0, and leaves the word unchanged, even at an implemented offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted (always 1) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address; word offset = reqAddr >> 3 |
| reqSize | input | 4 | Access size in bytes |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response, one cycle after acceptance |
| rspRdata | output | 64 | Read data |
| rspErr | output | 1 | Error pulse for bad offset or size |
| irqOut | output | 1 | Interrupt, bit 63 of the stored word |

## Verification
The three write paths are exercised with a grid of upper-half patterns: single set bits, their complements, all-ones, zero and mixed values. Each pattern also carries non-zero low bits. Chaining a direct write, an AND, then an OR over every pair of patterns tells the three operations apart, and any leak of the low 48 bits shows up on readback. Toggling bit 63 in these patterns separates a correct interrupt from a stale or mistimed one. A second instance in the clear variant is given non-zero data on the clear alias, to show the data is ignored. The offsets on both sides of the three-word window, and the sizes 1, 2 and 4, are swept to show the error pulse and that the word is kept.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;
  typedef struct packed {
    logic wrDirect;
    logic wrAnd;
    logic wrOr;
    logic wrClear;
    logic rdBase;
    logic respond;
    logic err;
  } strobe_t;
endpackage

// File: rtl/misc_alias_ctrl.sv
module misc_alias_ctrl
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int ACCESS_BYTES  = 8,
  parameter bit CLEAR_VARIANT = 1'b0,
  parameter int BASE_AND      = 'h4020,
  parameter int BASE_CLR      = 'h6080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  output strobe_t           stb
);
  localparam int OFF_W = ADDR_W - 3;
  localparam logic [OFF_W-1:0] BASE_OFF =
    OFF_W'(CLEAR_VARIANT ? BASE_CLR : BASE_AND);

  logic [OFF_W-1:0] wordOff;
  logic hitBase, hitAlt, hitOr, sizeOk, good, doWrite;
  logic altIsAnd, altIsClr;

  generate
    if (CLEAR_VARIANT) begin : gClearAlias
      assign altIsAnd = 1'b0;
      assign altIsClr = 1'b1;
    end else begin : gAndAlias
      assign altIsAnd = 1'b1;
      assign altIsClr = 1'b0;
    end
  endgenerate

  always_comb begin
    wordOff = reqAddr[ADDR_W-1:3];
    hitBase = (wordOff == BASE_OFF);
    hitAlt  = (wordOff == BASE_OFF + OFF_W'(1));
    hitOr   = (wordOff == BASE_OFF + OFF_W'(2));
    sizeOk  = (reqSize == 4'(ACCESS_BYTES));
    good    = accept && sizeOk && (hitBase || hitAlt || hitOr);
    doWrite = good && reqWrite;
    stb.respond  = accept;
    stb.err      = accept && !good;
    stb.wrDirect = doWrite && hitBase;
    stb.wrAnd    = doWrite && hitAlt && altIsAnd;
    stb.wrClear  = doWrite && hitAlt && altIsClr;
    stb.wrOr     = doWrite && hitOr;
    stb.rdBase   = good && !reqWrite && hitBase;
  end

  // R8 R9: at most one action per request, error excludes all updates
  a_r8_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDirect, stb.wrAnd, stb.wrOr, stb.wrClear, stb.rdBase, stb.err}));
  // R9: a wrong size never yields an update
  a_r9_size_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqSize != 4'(ACCESS_BYTES)) |-> stb.err);
endmodule

// File: rtl/misc_alias_dp.sv
module misc_alias_dp
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic              irqOut
);
  localparam int LOW_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] keepReg, nextKeep, wHi;
  logic irqQ;

  always_comb begin
    wHi = wdata[DATA_W-1 -: KEEP_W];
    nextKeep = keepReg;
    if (stb.wrDirect) nextKeep = wHi;
    if (stb.wrAnd)    nextKeep = keepReg & wHi;
    if (stb.wrOr)     nextKeep = keepReg | wHi;
    if (stb.wrClear)  nextKeep = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepReg  <= '0;
      irqQ     <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rdata    <= '0;
    end else begin
      keepReg  <= nextKeep;
      irqQ     <= nextKeep[KEEP_W-1];
      rspValid <= stb.respond;
      rspErr   <= stb.err;
      rdata    <= stb.rdBase ? {keepReg, {LOW_W{1'b0}}} : '0;
    end
  end

  assign irqOut = irqQ;

  // R6: interrupt flop tracks the top stored bit
  a_r6_irq_top_bit: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == keepReg[KEEP_W-1]);
  // R2
  a_r2_direct: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDirect |=> keepReg == $past(wdata[DATA_W-1 -: KEEP_W]));
  // R3
  a_r3_and: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAnd |=> keepReg == ($past(keepReg) & $past(wdata[DATA_W-1 -: KEEP_W])));
  // R4
  a_r4_or: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrOr |=> keepReg == ($past(keepReg) | $past(wdata[DATA_W-1 -: KEEP_W])));
  // R5
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClear |=> (keepReg == '0 && !irqOut));
  // R8 R9: an erroring request keeps the word
  a_r8_err_holds: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |=> ($stable(keepReg) && rspErr && rdata == '0));
  // R7
  a_r7_read_old: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdBase |=> rdata == {$past(keepReg), {LOW_W{1'b0}}});
endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 64,
  parameter int KEEP_W        = 16,
  parameter bit CLEAR_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              irqOut
);
  strobe_t stb;
  logic accept;

  assign reqReady = 1'b1;
  assign accept   = reqValid && reqReady;

  misc_alias_ctrl #(
    .ADDR_W(ADDR_W), .ACCESS_BYTES(DATA_W / 8), .CLEAR_VARIANT(CLEAR_VARIANT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .accept(accept), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .stb(stb)
  );

  misc_alias_dp #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata), .rdata(rspRdata),
    .rspValid(rspValid), .rspErr(rspErr), .irqOut(irqOut)
  );

  // R7: every accepted request is answered in the next cycle
  a_r7_response: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);
  // R7: no response without a request
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);
endmodule

// File: tb/tb_misc_alias_reg.sv
`timescale 1ns/1ps
module tb_misc_alias_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        validA, validB, reqWrite;
  logic        readyA, readyB;
  logic [31:0] reqAddr;
  logic [3:0]  reqSize;
  logic [63:0] reqWdata;
  logic        rvA, rvB, errA, errB, irqA, irqB;
  logic [63:0] rdA, rdB;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] modelA = '0, modelB = '0;

  localparam logic [63:0] HI = 64'hFFFF_0000_0000_0000;

  misc_alias_reg #(.CLEAR_VARIANT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .reqValid(validA), .reqReady(readyA),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .rspValid(rvA), .rspRdata(rdA), .rspErr(errA),
    .irqOut(irqA));

  misc_alias_reg #(.CLEAR_VARIANT(1'b1)) dutClr (
    .clk(clk), .rstN(rstN), .reqValid(validB), .reqReady(readyB),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .rspValid(rvB), .rspRdata(rdB), .rspErr(errB),
    .irqOut(irqB));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request to variant sel (0 = AND, 1 = clear); checks the response
  task automatic req(input bit sel, input bit wr, input int off,
                     input logic [3:0] sz, input logic [63:0] d, input string tag);
    logic [63:0] m, expRd;
    bit expErr;
    int base;
    base = sel ? 'h6080 : 'h4020;
    m = sel ? modelB : modelA;
    expErr = (sz != 4'd8) || (off < base) || (off > base + 2);
    expRd = '0;
    if (!expErr) begin
      if (!wr && off == base) expRd = m;
      if (wr) begin
        if (off == base) m = d & HI;
        else if (off == base + 1) m = sel ? 64'd0 : (m & d & HI);
        else m = (m | d) & HI;
      end
    end
    @(negedge clk);
    validA = !sel; validB = sel; reqWrite = wr;
    reqAddr = 32'(off) << 3; reqSize = sz; reqWdata = d;
    @(negedge clk);
    validA = 0; validB = 0;
    if (sel) modelB = m; else modelA = m;
    check({tag, " R7 rspValid"}, {63'd0, sel ? rvB : rvA}, 64'd1);
    check({tag, " R8 R9 rspErr"}, {63'd0, sel ? errB : errA}, {63'd0, expErr});
    check({tag, " R7 rdata"}, sel ? rdB : rdA, expRd);
    check({tag, " R6 irq"}, {63'd0, sel ? irqB : irqA}, {63'd0, m[63]});
  endtask

  logic [63:0] pats [8];

  initial begin
    validA = 0; validB = 0; reqWrite = 0; reqAddr = '0; reqSize = 4'd8; reqWdata = '0;
    pats[0] = 64'h0000_1234_5678_9ABC; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_0000_0001; pats[3] = 64'h7FFF_AAAA_5555_0000;
    pats[4] = 64'h0001_FFFF_FFFF_FFFF; pats[5] = 64'hA5A5_0000_0000_1111;
    pats[6] = 64'h5A5A_DEAD_BEEF_0000; pats[7] = 64'hC003_0F0F_0F0F_0F0F;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rspValid", {63'd0, rvA}, 64'd0);
    check("R1 rspErr",   {63'd0, errA}, 64'd0);
    check("R1 irq",      {63'd0, irqA | irqB}, 64'd0);
    rstN = 1;
    req(0, 0, 'h4020, 8, 0, "R1 read after reset");
    req(1, 0, 'h6080, 8, 0, "R1 read after reset clr");
    // R2 R3 R4 chained sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        req(0, 1, 'h4020, 8, pats[i], "R2 direct");
        req(0, 0, 'h4020, 8, 0, "R2 readback");
        req(0, 1, 'h4021, 8, pats[j], "R3 and");
        req(0, 0, 'h4020, 8, 0, "R3 readback");
        req(0, 1, 'h4022, 8, pats[(i + j) % 8], "R4 or");
        req(0, 0, 'h4020, 8, 0, "R4 readback");
      end
    // walking bit through upper half
    for (int b = 48; b < 64; b++) begin
      req(0, 1, 'h4020, 8, 64'd1 << b, "R2 walk");
      req(0, 1, 'h4022, 8, 64'h0000_FFFF_FFFF_FFFF, "R4 low bits dropped");
      req(0, 0, 'h4020, 8, 0, "R2 walk readback");
    end
    // R5 clear variant
    for (int i = 0; i < 8; i++) begin
      req(1, 1, 'h6080, 8, pats[i], "R2 clr direct");
      req(1, 1, 'h6082, 8, pats[7 - i], "R4 clr or");
      req(1, 0, 'h6080, 8, 0, "R4 clr readback");
      req(1, 1, 'h6081, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R5 clear");
      req(1, 0, 'h6080, 8, 0, "R5 readback");
    end
    // R7 alias reads, R8 window edges, R9 sizes
    req(0, 1, 'h4020, 8, 64'hBEEF_0000_0000_0000, "R2 setup");
    req(1, 1, 'h6080, 8, 64'h8421_0000_0000_0000, "R2 setup clr");
    for (int o = -2; o <= 4; o++) begin
      req(0, 0, 'h4020 + o, 8, 0, "R7 R8 read sweep");
      req(0, 1, 'h4020 + o, (o >= 0 && o <= 2) ? 4'd4 : 4'd8, 64'd0, "R8 R9 write sweep");
      req(1, 0, 'h6080 + o, 8, 0, "R7 R8 read sweep clr");
      req(1, 1, 'h6080 + o, (o >= 0 && o <= 2) ? 4'd2 : 4'd8, 64'd0, "R8 R9 write sweep clr");
    end
    for (int s = 0; s < 16; s++) begin
      req(0, 1, 'h4021, 4'(s), 64'd0, "R9 size");
      req(0, 0, 'h4020, 8, 0, "R9 size readback");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule